// File: doc/BRIEF.md
# Diagnostic Serial Slave Port for a Sixteen-Channel Switch Controller

This block is the serial slave port through which a host controller talks to a sixteen-channel low-side switch. The host pulls the active-low select pin low, toggles the serial clock and shifts a control word in, most significant bit first. In the same frame the block shifts a diagnostic status word out. The diagnostic word comes from the channel logic and is captured when select falls. When select rises after exactly sixteen accepted bits, the received word becomes the new parallel control word that drives the channels. A frame of any other length leaves the control word untouched.

All serial pins pass through synchronisers into a fast system clock domain. Edges are detected there, and timing limits are counted in system-clock cycles. A clock pulse is rejected in any of three cases: its rising edge comes too soon after select fell (the lead time), its low phase was too short, or its high phase was too short. The first clock pulse of each frame that meets the timing limits only primes the input stage. Data is taken from the next accepted pulse onward, so a full frame is seventeen pulses. The serial output has a separate enable that is low whenever select is high. An active-low reset clears both shift paths and forces the control word and the serial output off.

Top module: `diag_spi_slave`

## Requirements
- R1: While select is high, clock and data activity has no effect. The output enable stays low, the serial output stays 0 and the control word is unchanged.
- R2: An accepted data pulse samples the data input on the falling clock edge. Bits fill the word most significant first, so the first data bit of the frame ends up in control bit 15.
- R3: While select is low, the serial output shows bit 15 of the captured diagnostic word. Each accepted rising clock edge that follows at least one accepted data bit moves the next lower bit onto the output.
- R4: The diagnostic word is captured on the falling edge of select. Changes on the diagnostic input later in the frame have no effect on the serial output.
- R5: While reset is low, the control word is 0, the output enable is low and the serial output is 0. Reset also clears the frame state.
- R6: On the rising edge of select, the received word is copied to the control word if and only if exactly 16 data bits were accepted in that frame.
- R7: A first rising clock edge that comes fewer than LEAD_CYC system cycles after select fell rejects that pulse, with a default of 20.
- R8: A pulse is rejected if its high phase is shorter than HIGH_CYC cycles. It is also rejected if the low phase before its rising edge is shorter than LOW_CYC cycles. Both default to 5.
- R9: The first pulse of a frame that meets the timing limits carries no data. Its data bit is ignored.
- R10: A change on a serial pin shows on the outputs three system clocks later, one per synchroniser stage plus one for edge detection.
- R11: The output enable is high for the whole time select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low frame select from the host |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| diag_i | input | 16 | Diagnostic status word from the channel logic |
| sdo_o | output | 1 | Serial diagnostic data to the host |
| sdo_oe_o | output | 1 | Drive enable for the serial output |
| ctrl_o | output | 16 | Parallel control word to the channel logic |

## Verification
Every output is due three system clocks after the pin change that causes it. The bench's reference model acts on the pin values it sees at each clock edge. It places each expected output in a short queue, and the value compared on a given clock is the one the model produced two clocks earlier. Directed checks wait out this latency too. The control word is read at least eight cycles after select rises, and the serial output is read at the end of each high phase, which lasts longer than three cycles. The latency check itself looks at the output enable exactly two and three cycles after select falls.

// File: rtl/diag_spi_pkg.sv
package diag_spi_pkg;

  // True when the cycles elapsed since the last event reach a minimum.
  // 'since' is the counter value on the cycle the new event is seen; the
  // counter was cleared on the event cycle, so elapsed = since + 1.
  function automatic logic span_met(input int unsigned since, input int unsigned min_cyc);
    return (since + 1) >= min_cyc;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/diag_spi_sync.sv
module diag_spi_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
    end else begin
      pipe_q[0] <= din;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/diag_spi_edges.sv
module diag_spi_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic sck_s,
  output logic cs_low,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall
);
  logic cs_q, sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
    end
  end

  assign cs_low   = ~cs_s;
  assign cs_fall  = cs_q & ~cs_s;
  assign cs_rise  = ~cs_q & cs_s;
  assign sck_rise = ~sck_q & sck_s;
  assign sck_fall = sck_q & ~sck_s;
endmodule

// File: rtl/diag_spi_timing.sv
module diag_spi_timing
  import diag_spi_pkg::*;
#(
  parameter int unsigned LEAD_CYC = 20,
  parameter int unsigned HIGH_CYC = 5,
  parameter int unsigned LOW_CYC  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_low,
  input  logic cs_fall,
  input  logic sck_rise,
  input  logic sck_fall,
  output logic data_shift,
  output logic out_step,
  output logic prime_evt
);
  localparam int unsigned CNT_MAX = max3(LEAD_CYC, HIGH_CYC, LOW_CYC);
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);

  logic [CW-1:0] since_q;
  logic          first_q, primed_q, rise_good_q;
  logic          in_frame, rise_ok, fall_ok;

  assign in_frame = cs_low & ~cs_fall;
  assign rise_ok  = first_q ? span_met(32'(since_q), LEAD_CYC)
                            : span_met(32'(since_q), LOW_CYC);
  assign fall_ok  = rise_good_q & span_met(32'(since_q), HIGH_CYC);

  assign out_step   = in_frame & sck_rise & rise_ok;
  assign data_shift = in_frame & sck_fall & fall_ok & primed_q;
  assign prime_evt  = in_frame & sck_fall & fall_ok & ~primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q     <= '0;
      first_q     <= 1'b0;
      primed_q    <= 1'b0;
      rise_good_q <= 1'b0;
    end else if (cs_fall) begin
      since_q     <= '0;
      first_q     <= 1'b1;
      primed_q    <= 1'b0;
      rise_good_q <= 1'b0;
    end else if (in_frame && sck_rise) begin
      since_q     <= '0;
      first_q     <= 1'b0;
      rise_good_q <= rise_ok;
    end else if (in_frame && sck_fall) begin
      since_q <= '0;
      if (prime_evt) primed_q <= 1'b1;
    end else if (since_q != CW'(CNT_MAX)) begin
      since_q <= since_q + 1'b1;
    end
  end

  AST_LEAD_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && sck_rise && first_q && !span_met(32'(since_q), LEAD_CYC)) |=> !rise_good_q); // R7

  AST_LOW_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && sck_rise && !first_q && !span_met(32'(since_q), LOW_CYC)) |=> !rise_good_q); // R8

  AST_PRIME_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    prime_evt |=> primed_q); // R9
endmodule

// File: rtl/diag_spi_shift.sv
module diag_spi_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sdi_s,
  input  logic              data_shift,
  input  logic              out_step,
  input  logic [WORD_W-1:0] diag_i,
  output logic [WORD_W-1:0] ctrl_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [$clog2(WORD_W+2)-1:0] bit_cnt_o
);
  localparam int unsigned BW = $clog2(WORD_W + 2);

  logic [WORD_W-1:0] in_sr_q, out_sr_q;
  logic [BW-1:0]     bit_cnt_q;
  logic              out_en_q;
  logic              word_full;

  assign word_full = (bit_cnt_q == BW'(WORD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sr_q   <= '0;
      out_sr_q  <= '0;
      bit_cnt_q <= '0;
      out_en_q  <= 1'b0;
      ctrl_o    <= '0;
    end else if (cs_fall) begin
      out_sr_q  <= diag_i;
      in_sr_q   <= '0;
      bit_cnt_q <= '0;
      out_en_q  <= 1'b1;
    end else if (cs_rise) begin
      out_en_q <= 1'b0;
      if (word_full) ctrl_o <= in_sr_q;
    end else begin
      if (data_shift) begin
        in_sr_q <= {in_sr_q[WORD_W-2:0], sdi_s};
        if (bit_cnt_q != BW'(WORD_W + 1)) bit_cnt_q <= bit_cnt_q + 1'b1;
      end
      if (out_step && bit_cnt_q != '0) out_sr_q <= {out_sr_q[WORD_W-2:0], 1'b0};
    end
  end

  assign sdo_o     = out_en_q & out_sr_q[WORD_W-1];
  assign sdo_oe_o  = out_en_q;
  assign bit_cnt_o = bit_cnt_q;

  AST_DISCARD_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !word_full) |=> $stable(ctrl_o)); // R6

  AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && word_full) |=> (ctrl_o == $past(in_sr_q))); // R6

  AST_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> sdo_oe_o); // R11

  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (!sdo_oe_o && !sdo_o)); // R1
endmodule

// File: rtl/diag_spi_slave.sv
module diag_spi_slave #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LEAD_CYC    = 20,
  parameter int unsigned HIGH_CYC    = 5,
  parameter int unsigned LOW_CYC     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [WORD_W-1:0] diag_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [WORD_W-1:0] ctrl_o
);
  localparam int unsigned BW = $clog2(WORD_W + 2);

  // Synchronised pins, bit order {cs, sck, sdi}; idle values on reset.
  logic [2:0]    pins_s;
  logic          cs_low, cs_fall, cs_rise, sck_rise, sck_fall;
  logic          data_shift, out_step, prime_evt;
  logic [BW-1:0] bit_cnt;

  diag_spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({cs_n_i, sclk_i, sdi_i}), .dout(pins_s)
  );

  diag_spi_edges u_edges (
    .clk(clk), .rst_n(rst_n), .cs_s(pins_s[2]), .sck_s(pins_s[1]),
    .cs_low(cs_low), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  diag_spi_timing #(.LEAD_CYC(LEAD_CYC), .HIGH_CYC(HIGH_CYC), .LOW_CYC(LOW_CYC)) u_timing (
    .clk(clk), .rst_n(rst_n), .cs_low(cs_low), .cs_fall(cs_fall),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .data_shift(data_shift), .out_step(out_step), .prime_evt(prime_evt)
  );

  diag_spi_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sdi_s(pins_s[0]), .data_shift(data_shift), .out_step(out_step),
    .diag_i(diag_i), .ctrl_o(ctrl_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .bit_cnt_o(bit_cnt)
  );

  AST_PRIME_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    prime_evt |=> $stable(bit_cnt)); // R9

  AST_DATA_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_shift && bit_cnt < BW'(WORD_W)) |=> (bit_cnt == $past(bit_cnt) + 1'b1)); // R2

  AST_RESET_OFF: assert property (@(posedge clk)
    !rst_n |-> (ctrl_o == '0 && !sdo_oe_o && !sdo_o)); // R5
endmodule

// File: tb/tb_diag_spi_slave.sv
`timescale 1ns/1ps
module tb_diag_spi_slave;
  localparam int W = 16, LEAD = 20, HI = 5, LO = 5;

  logic clk = 1'b0, rst_n = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [W-1:0] diag = '0;
  logic sdo, oe;
  logic [W-1:0] ctrl;

  always #2.5 clk = ~clk;

  diag_spi_slave dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .diag_i(diag), .sdo_o(sdo), .sdo_oe_o(oe), .ctrl_o(ctrl)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model acting on raw pins at each clock edge.
  typedef struct { logic [W-1:0] c; logic s; logic e; } exp_t;
  exp_t q[$];
  int   m_since, m_cnt;
  bit   m_pcs, m_psck, m_first, m_primed, m_rgood, m_oe;
  logic [W-1:0] m_in, m_out, m_ctrl;

  task automatic model_reset();
    m_since = 0; m_cnt = 0; m_pcs = 1; m_psck = 0; m_first = 0; m_primed = 0;
    m_rgood = 0; m_oe = 0; m_in = '0; m_out = '0; m_ctrl = '0;
  endtask

  task automatic model_step();
    m_since++;
    if (m_pcs && !cs_n) begin
      m_out = diag; m_in = '0; m_cnt = 0; m_primed = 0; m_first = 1;
      m_rgood = 0; m_oe = 1; m_since = 0;
    end else if (!m_pcs && cs_n) begin
      if (m_cnt == W) m_ctrl = m_in;
      m_oe = 0;
    end else if (!cs_n) begin
      if (!m_psck && sclk) begin
        m_rgood = m_first ? (m_since >= LEAD) : (m_since >= LO);
        m_first = 0;
        if (m_rgood && m_cnt > 0) m_out = m_out << 1;
        m_since = 0;
      end else if (m_psck && !sclk) begin
        if (m_rgood && m_since >= HI) begin
          if (m_primed) begin
            m_in = {m_in[W-2:0], sdi};
            if (m_cnt < W + 1) m_cnt++;
          end else m_primed = 1;
        end
        m_since = 0;
      end
    end
    m_pcs = cs_n; m_psck = sclk;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    exp_t cur;
    if (!rst_n) begin
      model_reset();
      q.delete();
    end else begin
      model_step();
      cur.c = m_ctrl; cur.s = m_oe & m_out[W-1]; cur.e = m_oe;
      q.push_back(cur);
      if (q.size() > 3) void'(q.pop_front());
    end
    #1;
    if (!rst_n) begin
      chk("R5", "ctrl in reset", 32'(ctrl), 32'h0);
      chk("R5", "oe in reset", 32'(oe), 32'h0);
      chk("R5", "sdo in reset", 32'(sdo), 32'h0);
    end else if (q.size() == 3) begin
      chk("R6", "ctrl vs model", 32'(ctrl), 32'(q[0].c));
      chk("R3", "sdo vs model", 32'(sdo), 32'(q[0].s));
      chk("R11", "oe vs model", 32'(oe), 32'(q[0].e));
    end
  end

  task automatic frame(input logic [W-1:0] word, input int npulse, input int lead,
                       input int bad_hi, input int bad_lo, input int flip_at,
                       output logic [W-1:0] so_word);
    so_word = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (lead) @(negedge clk);
    for (int p = 0; p < npulse; p++) begin
      sclk = 1'b1;
      sdi  = (p == 0) ? 1'b1 : ((p <= W) ? word[W-p] : 1'b0);
      if (p == flip_at) diag = ~diag;
      repeat ((p == bad_hi) ? HI - 1 : HI) @(negedge clk);
      if (p >= 1 && p <= W) so_word[W-p] = sdo;
      sclk = 1'b0;
      repeat ((p == bad_lo) ? LO - 1 : LO) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [W-1:0] so, ref_ctrl;
    #1 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5", "ctrl after reset", 32'(ctrl), 32'h0);
    chk("R5", "oe after reset", 32'(oe), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R6 R9: full frame, priming bit 1 must not reach ctrl bit 15
    diag = 16'hA5C3;
    frame(16'h3C5A, 17, LEAD, -1, -1, -1, so);
    ref_ctrl = 16'h3C5A;
    chk("R2", "ctrl after full frame", 32'(ctrl), 32'(ref_ctrl));
    chk("R3", "serial diag word", 32'(so), 32'hA5C3);

    // R9: 16 pulses only gives 15 data bits -> discarded
    frame(16'hFFFF, 16, LEAD, -1, -1, -1, so);
    chk("R9", "ctrl after 16 pulses", 32'(ctrl), 32'(ref_ctrl));

    // R6: 17 data bits -> discarded
    frame(16'h1234, 18, LEAD, -1, -1, -1, so);
    chk("R6", "ctrl after long frame", 32'(ctrl), 32'(ref_ctrl));

    // R7: lead one cycle short, and far too short
    frame(16'h0F0F, 17, LEAD - 1, -1, -1, -1, so);
    chk("R7", "ctrl after lead 19", 32'(ctrl), 32'(ref_ctrl));
    frame(16'h0F0F, 17, 3, -1, -1, -1, so);
    chk("R7", "ctrl after lead 3", 32'(ctrl), 32'(ref_ctrl));

    // R8: one short high phase, then one short low phase
    frame(16'h5555, 17, LEAD, 5, -1, -1, so);
    chk("R8", "ctrl after short high", 32'(ctrl), 32'(ref_ctrl));
    frame(16'h5555, 17, LEAD, -1, 5, -1, so);
    chk("R8", "ctrl after short low", 32'(ctrl), 32'(ref_ctrl));

    // R4 R2: diag input changes mid-frame; MSB-first placement
    diag = 16'h6E91;
    frame(16'h8001, 17, LEAD, -1, -1, 6, so);
    ref_ctrl = 16'h8001;
    chk("R4", "serial word ignores late diag", 32'(so), 32'h6E91);
    chk("R2", "ctrl msb first", 32'(ctrl), 32'(ref_ctrl));

    // R10: output enable appears exactly three clocks after select falls
    diag = 16'h8000;
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10", "oe two clocks after select", 32'(oe), 32'h0);
    @(negedge clk);
    chk("R10", "oe three clocks after select", 32'(oe), 32'h1);
    chk("R3", "sdo shows diag bit 15", 32'(sdo), 32'h1);
    @(negedge clk) cs_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R6", "ctrl after empty frame", 32'(ctrl), 32'(ref_ctrl));

    // R1: clock activity with select high
    for (int p = 0; p < 17; p++) begin
      sclk = 1'b1; sdi = 1'b0;
      repeat (HI) @(negedge clk);
      sclk = 1'b0;
      repeat (LO) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R1", "ctrl with select high", 32'(ctrl), 32'(ref_ctrl));
    chk("R1", "oe with select high", 32'(oe), 32'h0);

    // R5: reset clears the control word
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5", "ctrl cleared by reset", 32'(ctrl), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5", "ctrl stays clear", 32'(ctrl), 32'h0);

    // R6: normal frame after reset
    diag = 16'h0FF0;
    frame(16'h7FFE, 17, LEAD, -1, -1, -1, so);
    chk("R6", "ctrl after frame post reset", 32'(ctrl), 32'h7FFE);
    chk("R3", "serial word post reset", 32'(so), 32'h0FF0);

    summary();
  end
endmodule